// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

This block raises a periodic event at a rate that software chooses. It runs from a 32768 Hz clock enable, `tick_en`, which is one system clock cycle wide and is made somewhere else. Software writes a reload divisor into a load register. For an event rate of F Hz, the divisor is 32768 / F.

A control register holds a run bit and an auto-start bit. When the timer starts, a down-counter copies the divisor. The counter then steps down by one on each tick. On the tick that finds it at 1, it reloads and the block pulses `period_irq` for one cycle. That pulse is the periodic status source for a shared interrupt mask and clear unit, which takes it on bit 1 of its registers.

Software reads the live count through the register port. The divisor cannot be changed while the timer runs, so the period cannot be corrupted in the middle of a count.

Top module: `ptt_top`

## Requirements
- R1: After reset, the count, divisor and control registers all read 0, and `period_irq` is low.
- R2: The register port decodes these byte addresses:
  - 0x20 is the live count. It is read-only, and writes to it are ignored.
  - 0x24 is the divisor. It can be read and written.
  - 0x28 is control. Bit 0 is auto-start and bit 1 is run. Bits 31:2 read 0.
  - Any other address reads 0.
- R3: A control write that takes the run bit from 0 to 1 copies the divisor into the count on that clock edge.
- R4: The count changes only on a cycle with `tick_en` high, or when a start loads it.
- R5: While running with a nonzero divisor N, each tick lowers the count by one. The tick that finds the count at 1 does three things:
  - it reloads the count with N;
  - it drives `period_irq` high for exactly the following cycle;
  - it completes a period of N ticks.
- R6: A divisor write while the run bit is 1 is ignored. The divisor readback and the period stay unchanged.
- R7: With auto-start set and run clear, a divisor write of a nonzero value does three things:
  - it stores the value;
  - it sets the run bit;
  - it loads the count with the value, with no separate control write.

  An auto-start write of 0 stores 0 and does not start the timer.
- R8: With a divisor of 0, the count stays at 0 and no `period_irq` pulse occurs, even when the run bit is 1.
- R9: Clearing the run bit freezes the count at its current value and stops all pulses.
- R10: A control write that keeps the run bit at 1 while the timer is running does not reload or disturb the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32768 Hz enable, one clock cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| period_irq | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume that a write lasts a single cycle, is qualified only by `wr_en`, and does not change the divisor while the timer runs. They also assume that `tick_en` is a clean synchronous level with no meaning outside the clock edge. The bench keeps to this:
- It raises every write strobe for one cycle.
- It generates each tick as a single-cycle pulse driven at the falling edge.
- It never overlaps a tick with a write, so each count step is unambiguous.

// File: rtl/ptt_pkg.sv
`timescale 1ns/1ps
package ptt_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Neighbouring interrupt logic and software decode these offsets
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h28;

    localparam int BIT_AUTO = 0;
    localparam int BIT_RUN  = 1;

    typedef struct packed {
        logic run;
        logic auto_go;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_RELOAD,
        SEL_CTRL
    } sel_e;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_COUNT:  return SEL_COUNT;
            OFS_RELOAD: return SEL_RELOAD;
            OFS_CTRL:   return SEL_CTRL;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/ptt_regs.sv
`timescale 1ns/1ps
module ptt_regs
    import ptt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [CNT_W-1:0]     load_q,
    output ctrl_t                ctrl_q,
    output logic                 start_req,
    output logic [CNT_W-1:0]     start_val
);
    sel_e sel;
    logic wr_load;
    logic wr_ctrl;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

    always_comb begin
        sel     = decode(addr);
        wr_load = wr_en && (sel == SEL_RELOAD) && !ctrl_q.run;
        wr_ctrl = wr_en && (sel == SEL_CTRL);
        start_req = (wr_ctrl && wdata[BIT_RUN] && !ctrl_q.run)
                 || (wr_load && ctrl_q.auto_go && (|wdata[CNT_W-1:0]));
        start_val = wr_ctrl ? load_q : wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_load)
                load_q <= wdata[CNT_W-1:0];
            if (wr_ctrl) begin
                ctrl_q.auto_go <= wdata[BIT_AUTO];
                ctrl_q.run     <= wdata[BIT_RUN];
            end else if (start_req) begin
                ctrl_q.run <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptt_counter.sv
`timescale 1ns/1ps
module ptt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             run,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start_req,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count_q,
    output logic             expire_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic active;
    assign active = tick_en && run && (load_val != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (start_req) begin
                count_q <= start_val;
            end else if (active) begin
                if (count_q <= ONE) begin
                    count_q  <= load_val;
                    expire_q <= 1'b1;
                end else begin
                    count_q <= count_q - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/ptt_top.sv
`timescale 1ns/1ps
module ptt_top
    import ptt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              period_irq
);
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] start_val;
    logic             start_req;
    ctrl_t            ctrl_q;
    logic             running;

    assign running = ctrl_q.run;

    ptt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .load_q    (load_q),
        .ctrl_q    (ctrl_q),
        .start_req (start_req),
        .start_val (start_val)
    );

    ptt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .run       (ctrl_q.run),
        .load_val  (load_q),
        .start_req (start_req),
        .start_val (start_val),
        .count_q   (count_q),
        .expire_q  (period_irq)
    );

    always_comb begin
        rdata = '0;
        case (decode(addr))
            SEL_COUNT:  rdata[CNT_W-1:0] = count_q;
            SEL_RELOAD: rdata[CNT_W-1:0] = load_q;
            SEL_CTRL:   rdata[1:0]       = {ctrl_q.run, ctrl_q.auto_go};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptt_checker.sv
`timescale 1ns/1ps
module ptt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic             period_irq,
    input logic             running,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] load_q
);
    // R5: a pulse follows a tick edge and leaves the count reloaded
    a_r5_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
        period_irq |-> $past(tick_en));
    a_r5_reloaded_on_pulse: assert property (@(posedge clk) disable iff (rst)
        period_irq |-> (count_q == load_q));
    // R4: no tick and no write means the count holds
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_en) |=> $stable(count_q));
    // R6: divisor locked while running
    a_r6_load_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h24 && running) |=> $stable(load_q));
    // R8: zero divisor never pulses
    a_r8_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (load_q == '0) |=> !period_irq);
    // R9: stopped timer does not count
    a_r9_stopped_frozen: assert property (@(posedge clk) disable iff (rst)
        (!running && !wr_en) |=> ($stable(count_q) && !period_irq));
endmodule

bind ptt_top ptt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .period_irq (period_irq),
    .running    (running),
    .count_q    (count_q),
    .load_q     (load_q)
);

// File: tb/tb_ptt_top.sv
`timescale 1ns/1ps
module tb_ptt_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        period_irq;

    int checks = 0;
    int failures = 0;

    localparam logic [7:0] A_CNT  = 8'h20;
    localparam logic [7:0] A_LOAD = 8'h24;
    localparam logic [7:0] A_CTRL = 8'h28;

    always #2.5 clk = ~clk;

    ptt_top dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .period_irq(period_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
            if (period_irq) hits++;
            @(negedge clk);
            if (period_irq) begin
                failures++; checks++;
                $display("FAIL R5 pulse longer than one cycle actual=1 expected=0");
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_LOAD, v); check("R1 divisor", v, 0);
        rd(A_CTRL, v); check("R1 control", v, 0);
        check("R1 irq", {31'b0, period_irq}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_CNT, 32'd5);
        rd(A_CNT, v);  check("R2 count read-only", v, 0);
        rd(8'h2C, v);  check("R2 unmapped", v, 0);
        wr(A_LOAD, 32'd7);
        rd(A_LOAD, v); check("R2 divisor rw", v, 7);
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd(A_CTRL, v); check("R2 control bits", v, 1);
        wr(A_CTRL, 32'd0);
    endtask

    task automatic t_period();
        logic [31:0] v;
        int h;
        wr(A_LOAD, 32'd4);
        wr(A_CTRL, 32'd2);
        rd(A_CNT, v); check("R3 start copies divisor", v, 4);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); check("R4 idle holds", v, 4);
        ticks(3, h);
        check("R5 no early pulse", h, 0);
        rd(A_CNT, v); check("R5 count down", v, 1);
        ticks(1, h);
        check("R5 pulse at expiry", h, 1);
        rd(A_CNT, v); check("R5 reload", v, 4);
        ticks(8, h);
        check("R5 period of 4", h, 2);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        int h;
        wr(A_LOAD, 32'd9);
        rd(A_LOAD, v); check("R6 divisor locked", v, 4);
        ticks(1, h);
        wr(A_CTRL, 32'd2);
        rd(A_CNT, v); check("R10 no restart", v, 3);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int h;
        wr(A_CTRL, 32'd0);
        ticks(5, h);
        check("R9 no pulses", h, 0);
        rd(A_CNT, v); check("R9 frozen", v, 3);
    endtask

    task automatic t_auto();
        logic [31:0] v;
        int h;
        wr(A_CTRL, 32'd1);
        wr(A_LOAD, 32'd3);
        rd(A_CTRL, v); check("R7 run set", v, 3);
        rd(A_CNT, v);  check("R7 count loaded", v, 3);
        ticks(3, h);
        check("R7 period 3", h, 1);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int h;
        wr(A_CTRL, 32'd1);
        wr(A_LOAD, 32'd0);
        rd(A_CTRL, v); check("R7 zero does not start", v, 1);
        wr(A_CTRL, 32'd3);
        rd(A_CNT, v); check("R8 count zero", v, 0);
        ticks(5, h);
        check("R8 no pulses", h, 0);
        rd(A_CNT, v); check("R8 count stays zero", v, 0);
    endtask

    initial begin
        #(200000 * 5);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_period();
        t_lock();
        t_stop();
        t_auto();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule